// File: doc/BRIEF.md
# Leveled Priority Interrupt Controller

This block collects interrupt request lines from a set of peripherals and picks a single request to offer the CPU. Software gives each source a 3-bit priority through a small register port. Every source has its own field, and values run from 0 (lowest) to 7 (highest). The offered request carries its level and a vector number. The vector number is the source index plus a fixed base.

The controller also drives a wake-up line for HALT and SLEEP. This line follows the raw pending inputs directly, so a source at level 0 still wakes the core even though it is never offered as an interrupt.

The CPU-facing outputs are level-type status, not a stream: they hold their value for as long as their inputs hold theirs. There is no handshake and no back-pressure. The CPU acts on them at its own pace, and a request disappears only when the source drops its pending line or its level is set to 0.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Each source owns a 3-bit level register. A write with `cfg_wr`=1 stores `cfg_wlvl` into the field selected by `cfg_idx` at the clock edge. `cfg_rlvl` shows the field selected by `cfg_idx` with no delay.
- R2: After reset, every level field reads 0, and `irq_valid`, `irq_level` and `irq_vector` are all 0.
- R3: A pending source whose level is 0 is never offered: with only such sources pending, `irq_valid` stays 0.
- R4: `wake` is 1 in the same cycle that any bit of `pend` is 1, whatever the levels are. It is 0 when `pend` is all zeros.
- R5: When several eligible sources are pending, the one with the numerically largest level is offered.
- R6: When the largest level is shared by several pending sources, the source with the smallest index (and so the lowest vector) is offered.
- R7: While `irq_valid` is 1:
  - `irq_vector` equals `VEC_BASE` plus the winning source index, with `VEC_BASE` defaulting to 16.
  - `irq_level` equals that source's level.
- R8: `irq_valid`, `irq_level` and `irq_vector` are registered. They reflect the pending inputs and level registers as sampled at the previous clock edge, so a level write shows at the outputs one edge after it is stored.
- R9: When no source with a non-zero level is pending, `irq_valid` is 0 and both `irq_level` and `irq_vector` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pend | input | NUM_SRC | Pending request line per source |
| cfg_wr | input | 1 | Level register write strobe |
| cfg_idx | input | $clog2(NUM_SRC) | Source selected for write and read |
| cfg_wlvl | input | 3 | Level value to write |
| cfg_rlvl | output | 3 | Level of the selected source |
| irq_valid | output | 1 | An eligible request is offered |
| irq_level | output | 3 | Level of the offered request |
| irq_vector | output | VEC_W | Vector number of the offered request |
| wake | output | 1 | HALT/SLEEP wake-up, any pending line |

## Verification
The timing of each output is as follows:
- `wake` is combinational, so it is checked a fraction of a cycle after `pend` is driven, before any clock edge.
- A change on `pend` reaches the registered outputs after one rising edge.
- A level write needs two rising edges: one to store the level and one to register the new pick.

The bench drives all inputs on the falling edge and samples on a later falling edge. The table loop waits two edges after its last write. The directed latency tests sample once after the first edge, to see the old value, and again after the second edge, to see the new one.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int LVL_W = 3;
  typedef logic [LVL_W-1:0] lvl_t;
  localparam lvl_t LVL_OFF = '0;
endpackage

// File: rtl/prio_lvl_bank.sv
module prio_lvl_bank
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         sel,
  input  lvl_t                     wr_lvl,
  output lvl_t                     rd_lvl,
  output logic [NUM_SRC*LVL_W-1:0] lvl_flat
);

  lvl_t lvl_q [NUM_SRC];

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_field
    always_ff @(posedge clk) begin
      if (rst)
        lvl_q[g] <= LVL_OFF;
      else if (wr_en && sel == IDX_W'(g))
        lvl_q[g] <= wr_lvl;
    end
    assign lvl_flat[g*LVL_W +: LVL_W] = lvl_q[g];
  end

  always_comb begin
    rd_lvl = LVL_OFF;
    for (int i = 0; i < NUM_SRC; i++)
      if (sel == IDX_W'(i)) rd_lvl = lvl_q[i];
  end

  // R1: a write lands in the addressed field on the next edge
  a_r1_write_lands: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (lvl_flat[$past(sel)*LVL_W +: LVL_W] == $past(wr_lvl)));

  // R2: fields come out of reset cleared
  a_r2_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (lvl_flat == '0));

endmodule

// File: rtl/prio_pick.sv
module prio_pick
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0]       pend,
  input  logic [NUM_SRC*LVL_W-1:0] lvl_flat,
  output logic                     hit,
  output lvl_t                     win_lvl,
  output logic [IDX_W-1:0]         win_idx
);

  // Ascending scan with strict compare: a later index only wins on a
  // strictly larger level, so equal levels keep the lowest index.
  // Starting from level 0 excludes level-0 sources automatically.
  always_comb begin
    win_lvl = LVL_OFF;
    win_idx = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pend[i] && (lvl_flat[i*LVL_W +: LVL_W] > win_lvl)) begin
        win_lvl = lvl_flat[i*LVL_W +: LVL_W];
        win_idx = IDX_W'(i);
      end
    end
    hit = (win_lvl != LVL_OFF);
  end

  // R3: a hit always carries a non-zero level from a pending source
  always_comb begin
    a_r3_hit_nonzero: assert (!hit || (pend[win_idx] &&
      lvl_flat[win_idx*LVL_W +: LVL_W] == win_lvl && win_lvl != LVL_OFF));
  end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC  = 8,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 16,
  localparam int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] pend,
  input  logic               cfg_wr,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic [LVL_W-1:0]   cfg_wlvl,
  output logic [LVL_W-1:0]   cfg_rlvl,
  output logic               irq_valid,
  output logic [LVL_W-1:0]   irq_level,
  output logic [VEC_W-1:0]   irq_vector,
  output logic               wake
);

  logic [NUM_SRC*LVL_W-1:0] lvl_flat;
  logic                     pick_hit;
  lvl_t                     pick_lvl;
  logic [IDX_W-1:0]         pick_idx;

  prio_lvl_bank #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst(rst), .wr_en(cfg_wr), .sel(cfg_idx),
    .wr_lvl(cfg_wlvl), .rd_lvl(cfg_rlvl), .lvl_flat(lvl_flat)
  );

  prio_pick #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_pick (
    .pend(pend), .lvl_flat(lvl_flat), .hit(pick_hit),
    .win_lvl(pick_lvl), .win_idx(pick_idx)
  );

  always_ff @(posedge clk) begin
    if (rst || !pick_hit) begin
      irq_valid  <= 1'b0;
      irq_level  <= LVL_OFF;
      irq_vector <= '0;
    end else begin
      irq_valid  <= 1'b1;
      irq_level  <= pick_lvl;
      irq_vector <= VEC_W'(VEC_BASE) + VEC_W'(pick_idx);
    end
  end

  // Wake follows raw pending lines; level has no say.
  assign wake = |pend;

  logic [VEC_W-1:0] out_idx;
  assign out_idx = irq_vector - VEC_W'(VEC_BASE);

  // R9: idle outputs read zero
  a_r9_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !irq_valid |-> (irq_level == '0 && irq_vector == '0));

  // R7: vector stays inside the block's range
  a_r7_vec_range: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> (irq_vector >= VEC_W'(VEC_BASE) &&
                   irq_vector <  VEC_W'(VEC_BASE + NUM_SRC)));

  // R8: offered source was pending at the previous edge
  a_r8_winner_was_pending: assert property (@(posedge clk) disable iff (rst)
    (irq_valid && !$past(rst)) |-> ((($past(pend) >> out_idx) & 1) != 0));

  // R4: an offered request implies wake was up when it was sampled
  a_r4_wake_before_valid: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_valid) |-> $past(wake));

endmodule

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int NV = 10;

  logic       clk = 0;
  logic       rst;
  logic [7:0] pend;
  logic       cfg_wr;
  logic [2:0] cfg_idx;
  logic [2:0] cfg_wlvl;
  logic [2:0] cfg_rlvl;
  logic       irq_valid;
  logic [2:0] irq_level;
  logic [7:0] irq_vector;
  logic       wake;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_irq_ctrl dut_i (
    .clk(clk), .rst(rst), .pend(pend), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
    .cfg_wlvl(cfg_wlvl), .cfg_rlvl(cfg_rlvl), .irq_valid(irq_valid),
    .irq_level(irq_level), .irq_vector(irq_vector), .wake(wake)
  );

  // Vector table: pending mask, levels (source i at bits 3i+2..3i), expected outputs
  localparam logic [7:0]  T_PEND [NV] = '{8'h01, 8'h81, 8'h0C, 8'hFF, 8'hFF,
                                          8'h7F, 8'hA0, 8'h00, 8'h12, 8'h06};
  localparam logic [23:0] T_LVLS [NV] = '{24'h000005, 24'hC00002, 24'h000900,
                                          24'h000000, 24'hFAC688, 24'hFAC688,
                                          24'hFFFFFF, 24'hFFFFFF, 24'h001008,
                                          24'h0000C0};
  localparam logic        T_EV   [NV] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1,
                                          1'b1, 1'b1, 1'b0, 1'b1, 1'b1};
  localparam logic [2:0]  T_EL   [NV] = '{3'd5, 3'd6, 3'd4, 3'd0, 3'd7,
                                          3'd6, 3'd7, 3'd0, 3'd1, 3'd3};
  localparam logic [7:0]  T_EVEC [NV] = '{8'd16, 8'd23, 8'd18, 8'd0, 8'd23,
                                          8'd22, 8'd21, 8'd0, 8'd17, 8'd18};

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_lvl(input int idx, input logic [2:0] v);
    cfg_wr   = 1'b1;
    cfg_idx  = 3'(idx);
    cfg_wlvl = v;
    step();
    cfg_wr   = 1'b0;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    rst = 1; pend = '0; cfg_wr = 0; cfg_idx = '0; cfg_wlvl = '0;
    @(negedge clk);
    step(); step();
    rst = 0;
    step();

    // R2: reset state
    check("R2 valid", irq_valid, 0);
    check("R2 level", irq_level, 0);
    check("R2 vector", irq_vector, 0);
    for (int i = 0; i < N; i++) begin
      cfg_idx = 3'(i);
      #1 check("R2 field", cfg_rlvl, 0);
    end

    // R3 R4: level-0 source wakes but is not offered
    pend = 8'h10;
    #1 check("R4 wake level0", wake, 1);
    step(); step();
    check("R3 level0 not offered", irq_valid, 0);
    pend = 8'h00;
    #1 check("R4 wake idle", wake, 0);

    // R1: write and read back
    wr_lvl(3, 3'd6);
    cfg_idx = 3'd3;
    #1 check("R1 readback", cfg_rlvl, 6);
    cfg_idx = 3'd2;
    #1 check("R1 neighbour untouched", cfg_rlvl, 0);

    // R8: pend change shows after exactly one edge
    pend = 8'h08;
    #1 check("R8 before edge", irq_valid, 0);
    step();
    check("R8 one edge valid", irq_valid, 1);
    check("R7 vector", irq_vector, 19);
    check("R7 level", irq_level, 6);

    // R8: level write shows one edge after it is stored
    wr_lvl(5, 3'd7);
    pend = 8'h28;
    step();
    check("R8 write latency old", irq_vector, 21);
    wr_lvl(3, 3'd0);
    pend = 8'h08;
    check("R8 level stored not yet out", irq_valid, 1);
    step();
    check("R3 R9 after level cleared valid", irq_valid, 0);
    check("R9 vector zero", irq_vector, 0);
    check("R9 level zero", irq_level, 0);

    // Table walk: R5 R6 R7 R9 R3
    for (int v = 0; v < NV; v++) begin
      for (int i = 0; i < N; i++) wr_lvl(i, T_LVLS[v][3*i +: 3]);
      pend = T_PEND[v];
      #1 check("R4 wake table", wake, (T_PEND[v] != 0));
      step(); step();
      check("R5 R6 valid", irq_valid, T_EV[v]);
      check("R5 level", irq_level, T_EL[v]);
      check("R6 R7 vector", irq_vector, T_EVEC[v]);
    end

    // R6: tie at top level across all sources picks lowest index
    for (int i = 0; i < N; i++) wr_lvl(i, 3'd2);
    pend = 8'hF0;
    step(); step();
    check("R6 tie lowest", irq_vector, 20);

    done = 1;
    finish_run();
  end
endmodule